// File: doc/BRIEF.md
# Differential SAR Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter built around a differential capacitive DAC. While idle it keeps the sampling switches closed so the capacitor arrays track the input, and it reports low power. A falling edge on the active-low chip select ends acquisition and starts a conversion. The controller first opens the sampling switches for one cycle with every DAC element at ground. It then resolves one bit per clock from the most significant bit down to the least significant bit, using the comparator decision at each step.

After the last bit the block closes the sampling switches again and reports power-down. It latches the code as a bipolar two's complement word and pulses a done flag. There is no pipeline latency: each result belongs to the sample taken at the chip-select edge that started that conversion. A new conversion is accepted only after a minimum acquisition window measured in clock cycles, and a chip-select edge during a conversion is ignored.

Top module: `sar_conv_seq`

## Requirements
- R1: During and straight after reset, sample_en is 1, pwr_dn is 1, dac_sw is all zero, done is 0 and result is 0x0000.
- R2: A 1-to-0 transition of cs_n, sampled by clk while the block is in acquisition and the acquisition window is complete, starts a conversion. In the next cycle sample_en and pwr_dn are 0 and dac_sw is all zero, so the switches open before any bit trial.
- R3: In the cycle after the switch-open cycle, dac_sw holds only bit 15 (0x8000). In each later trial cycle, the bits above the current trial bit hold the decided bits, the trial bit is 1 and the lower bits are 0. A trial bit is kept when cmp_below is 1 (DAC at or below the input) and cleared when it is 0.
- R4: The latched result is the decided offset-binary word with bit 15 inverted. An input equal to DAC code 0x8000 gives 0x0000, 0x8001 gives 0x0001 and 0x7FFF gives 0xFFFF.
- R5: An input above full scale (cmp_below always 1) gives 0x7FFF. An input below negative full scale (cmp_below always 0) gives 0x8000.
- R6: done is a one-cycle pulse. It is seen 18 cycles (NBITS+2) after the clock edge that detects the cs_n fall. In that same cycle result is valid, sample_en and pwr_dn are 1, and dac_sw is zero.
- R7: A cs_n fall during a conversion is ignored: the conversion ends with the normal latency and no further conversion follows.
- R8: A cs_n fall less than ACQ_CYCLES (80) cycles after reset or after the end of a conversion is ignored: sample_en stays 1 and no done follows.
- R9: result keeps its value in every cycle that does not latch a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select; its falling edge starts a conversion |
| cmp_below | input | 1 | Comparator: 1 when the DAC level is at or below the held input |
| dac_sw | output | 16 | Switch-control word, one bit per binary-weighted DAC element (1 = reference) |
| sample_en | output | 1 | Sampling switches closed (acquisition) |
| pwr_dn | output | 1 | Low-power indication between conversions |
| result | output | 16 | Two's complement conversion result |
| done | output | 1 | One-cycle pulse when result is latched |

## Verification
Latency is counted from the clock edge that detects the cs_n fall. The switch-open state shows one cycle later. The MSB trial shows two cycles later, and bit 15-j is on trial j+2 cycles later. done and the new result show NBITS+2 = 18 cycles later. The bench drives cs_n at falling clock edges and samples at every following falling edge. It checks the trial word expected for that exact cycle from its own model of the comparator, and it requires done to rise on cycle 18 and no other. For the ignored-edge cases it watches sample_en and done over a window longer than a full conversion.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_OPEN  = 2'd1,
    ST_TRIAL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_acq_timer.sv
`timescale 1ns/1ps
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_acq,
  output logic acq_ok
);
  localparam int CW = $clog2(ACQ_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ACQ_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!in_acq)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign acq_ok = (cnt == LIMIT);

  // R8
  acq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_acq |=> !acq_ok);
endmodule

// File: rtl/sar_bit_engine.sv
`timescale 1ns/1ps
module sar_bit_engine #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_below,
  output logic [NBITS-1:0] dac_sw,
  output logic             last,
  output logic [NBITS-1:0] final_word
);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(NBITS - 1);

  logic [NBITS-1:0] sar;
  logic [IW-1:0]    idx;

  // keep or drop the trial bit, then raise the next lower one
  function automatic logic [NBITS-1:0] resolve(input logic [NBITS-1:0] w_in,
                                               input logic [IW-1:0] i,
                                               input logic keep);
    logic [NBITS-1:0] w;
    w = w_in;
    if (!keep) w[i] = 1'b0;
    if (i != '0) w[i - 1'b1] = 1'b1;
    return w;
  endfunction

  function automatic logic [NBITS-1:0] msb_only();
    logic [NBITS-1:0] w;
    w = '0;
    w[NBITS-1] = 1'b1;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sar <= '0;
      idx <= '0;
    end else if (load) begin
      sar <= msb_only();
      idx <= TOP_IDX;
    end else if (step) begin
      sar <= resolve(sar, idx, cmp_below);
      if (idx != '0) idx <= idx - 1'b1;
    end
  end

  assign dac_sw     = step ? sar : '0;
  assign last       = (idx == '0);
  assign final_word = resolve(sar, idx, cmp_below);

  // R3
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ($countones(dac_sw) == 1) && dac_sw[NBITS-1]);
  // R3
  one_new_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> $countones(dac_sw & ~$past(dac_sw)) == 1);
endmodule

// File: rtl/sar_result_fmt.sv
`timescale 1ns/1ps
module sar_result_fmt #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [NBITS-1:0] word,
  output logic [NBITS-1:0] result,
  output logic             done
);
  // offset binary to two's complement: flip the sign bit
  function automatic logic [NBITS-1:0] to_twos(input logic [NBITS-1:0] w);
    logic [NBITS-1:0] r;
    r = w;
    r[NBITS-1] = ~w[NBITS-1];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= capture;
      if (capture) result <= to_twos(word);
    end
  end

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result));
endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq #(
  parameter int NBITS      = 16,
  parameter int ACQ_CYCLES = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cmp_below,
  output logic [NBITS-1:0] dac_sw,
  output logic             sample_en,
  output logic             pwr_dn,
  output logic [NBITS-1:0] result,
  output logic             done
);
  import sar_seq_pkg::*;

  seq_state_t       state;
  logic             cs_q;
  logic             cs_fall;
  logic             in_acq;
  logic             acq_ok;
  logic             start;
  logic             load;
  logic             step;
  logic             last;
  logic             capture;
  logic [NBITS-1:0] final_word;

  assign cs_fall = cs_q & ~cs_n;
  assign in_acq  = (state == ST_ACQ);
  assign start   = cs_fall & in_acq & acq_ok;
  assign load    = (state == ST_OPEN);
  assign step    = (state == ST_TRIAL);
  assign capture = step & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_ACQ;
      cs_q  <= 1'b1;
    end else begin
      cs_q <= cs_n;
      unique case (state)
        ST_ACQ:   if (start) state <= ST_OPEN;
        ST_OPEN:  state <= ST_TRIAL;
        ST_TRIAL: if (last) state <= ST_ACQ;
        default:  state <= ST_ACQ;
      endcase
    end
  end

  assign sample_en = in_acq;
  assign pwr_dn    = in_acq;

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .in_acq(in_acq), .acq_ok(acq_ok)
  );

  sar_bit_engine #(.NBITS(NBITS)) u_engine (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .cmp_below(cmp_below), .dac_sw(dac_sw), .last(last),
    .final_word(final_word)
  );

  sar_result_fmt #(.NBITS(NBITS)) u_fmt (
    .clk(clk), .rst_n(rst_n), .capture(capture), .word(final_word),
    .result(result), .done(done)
  );

  // R2
  open_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) |-> (dac_sw == '0) && !pwr_dn);
  // R8
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> acq_ok && sample_en);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sample_en && pwr_dn && (dac_sw == '0));
endmodule

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
  localparam int N   = 16;
  localparam int ACQ = 80;
  localparam int FS  = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         cmp_below;
  logic [N-1:0] dac_sw;
  logic         sample_en, pwr_dn, done;
  logic [N-1:0] result;
  int           vin_code = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           finished = 1'b0;

  always #2.5 clk = ~clk;

  // comparator model: DAC at or below the held input
  assign cmp_below = (int'(dac_sw) <= vin_code);

  sar_conv_seq #(.NBITS(N), .ACQ_CYCLES(ACQ)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmp_below(cmp_below),
    .dac_sw(dac_sw), .sample_en(sample_en), .pwr_dn(pwr_dn),
    .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_code(input int v);
    if (v < 0) return 0;
    if (v > FS) return FS;
    return v;
  endfunction

  function automatic int expect_result(input int v);
    return clamp_code(v) ^ (1 << (N - 1));
  endfunction

  function automatic int expect_trial(input int code, input int bitpos);
    int upper;
    upper = code & ~((1 << (bitpos + 1)) - 1);
    return upper | (1 << bitpos);
  endfunction

  // one conversion; glitch=1 re-drops cs_n in the middle (R7)
  task automatic run_conv(input int v, input bit glitch, input string tag);
    int got = 0;
    int exp_c = clamp_code(v);
    int exp_r = expect_result(v);
    int held;
    @(negedge clk) cs_n = 1'b1;
    repeat (ACQ + 4) @(negedge clk);
    vin_code = v;
    cs_n = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(!sample_en && !pwr_dn && dac_sw == '0, "R2 switch-open cycle",
            {sample_en, pwr_dn, 16'(dac_sw)}, 0);
      end
      if (k >= 2 && k <= N + 1) begin
        int bp = N + 1 - k;
        chk(int'(dac_sw) == expect_trial(exp_c, bp), "R3 trial word",
            int'(dac_sw), expect_trial(exp_c, bp));
      end
      if (glitch && k == 5) cs_n = 1'b1;
      if (glitch && k == 6) cs_n = 1'b0;
      if (done) begin
        got = k;
        break;
      end
    end
    chk(got == N + 2, "R6 done latency", got, N + 2);
    chk(int'(result) == exp_r, tag, int'(result), exp_r);
    chk(sample_en && pwr_dn && dac_sw == '0, "R6 idle with done",
        {sample_en, pwr_dn, 16'(dac_sw)}, 32'h30000);
    held = int'(result);
    @(negedge clk);
    chk(!done, "R6 done single pulse", done, 0);
    chk(int'(result) == held, "R9 result hold", int'(result), held);
  endtask

  // cs_n drop that must be ignored (R8)
  task automatic early_fall(input int gap);
    bit bad = 1'b0;
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
    cs_n = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!sample_en || done) bad = 1'b1;
    end
    chk(!bad, "R8 early cs_n fall ignored", bad, 0);
    cs_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd57));
    repeat (3) @(negedge clk);
    // R1
    chk(sample_en && pwr_dn && !done && dac_sw == '0 && result == '0,
        "R1 reset state", {sample_en, pwr_dn, done, 16'(result)}, 32'h60000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample_en && pwr_dn && !done && result == '0, "R1 after release",
        {sample_en, pwr_dn, done}, 6);
    // R8: too soon after reset
    early_fall(3);

    // R4 directed codes
    run_conv(32'h8000, 1'b0, "R4 midscale");
    run_conv(32'h8001, 1'b0, "R4 midscale plus one");
    run_conv(32'h7FFF, 1'b0, "R4 midscale minus one");
    run_conv(0, 1'b0, "R4 zero code");
    run_conv(1, 1'b0, "R4 negative fs plus one");
    run_conv(FS, 1'b0, "R4 top code");
    // R5 saturation
    run_conv(FS + 5000, 1'b0, "R5 over-range");
    run_conv(-20, 1'b0, "R5 under-range");

    // R8: too soon after a conversion
    early_fall(4);

    // R7: cs_n drop mid conversion, then no further conversion
    run_conv(32'h1234, 1'b1, "R7 glitched conversion result");
    begin
      bit extra = 1'b0;
      for (int k = 0; k < ACQ + 30; k++) begin
        @(negedge clk);
        if (done || !sample_en) extra = 1'b1;
      end
      chk(!extra, "R7 no second conversion", extra, 0);
    end

    // random inputs, R4
    for (int i = 0; i < 24; i++) begin
      int v = int'($urandom_range(FS, 0));
      run_conv(v, 1'b0, "R4 random code");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule